// File: doc/BRIEF.md
# Counter Clock and Gate Source Selector

This block sits in front of a bank of counter channels and decides, for each channel, what it counts and when it is allowed to count. The channels are arranged as groups of three. Every channel owns two 5-bit selection registers, one choosing its clock source and one choosing its gate source. Software writes and reads them over a small synchronous register port. The block produces one count-enable pulse and one gate level per channel, and it also drives the direction controls for each channel's own clock and gate connector pins.

Clock sources include the channel's own pin and the group's shared external clock. Five internal rates come from a divider chain running on the 20 MHz system clock, and the full system clock rate is also available. Other sources are fixed levels, a pattern-status signal and the output of the neighbouring counter. Neighbour links run through all channels as a ring that crosses group boundaries. Gate sources add inverted pin and neighbour options and three pattern-status levels with their complements. An extended-mode input opens the upper part of the code space. Every level input is taken to be synchronous to `clk`. A clock source counts on its rising edge, so `clk_tick` is high for exactly one cycle per counted edge.

Top module: `ctr_route_matrix`

## Requirements
- R1: After reset every clock-select and gate-select register reads 0, `clk_pin_oe` is all zeros and `gate_pin_oe` is all ones.
- R2: Register address layout: `reg_addr[0]` = 0 selects the clock register and 1 selects the gate register; `reg_addr[ADDR_W-1:1]` is the flat channel index (group*3 + channel). A write takes effect at the next clock edge. `reg_rdata` shows the addressed register combinationally. Channel indices at or beyond the channel count read 0, and writes to them change no register.
- R3: Clock code 0 ticks in the cycle in which the channel's own `clk_pin_in` is first seen high after being low. Code 7 ticks likewise on the rising edge of `grp_ext_clk` of the channel's group. No other input makes these codes tick.
- R4: Clock codes 1, 2, 3, 4 and 5 give one tick every FIRST_DIV, FIRST_DIV*DEC_DIV, FIRST_DIV*DEC_DIV^2, FIRST_DIV*DEC_DIV^3 and FIRST_DIV*DEC_DIV^4 cycles respectively. With the defaults these are 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. With `ext_mode` = 1, code 11 ticks on every cycle.
- R5: Clock code 6 ticks on the rising edge of `ctr_out` of the preceding channel. That is the previous channel of the same group, and for channel 0 it is channel 2 of the previous group; group 0 wraps to the last group.
- R6: With `ext_mode` = 1, codes 8 (high) and 9 (low) never tick, and code 10 ticks on the rising edge of `pat_present`. With `ext_mode` = 0, codes 8 to 31 never tick; with `ext_mode` = 1, codes 12 to 31 never tick.
- R7: Gate code 0 gives gate 1 and code 1 gives gate 0. Code 2 passes `gate_pin_in`. Code 3 gives the inverted `ctr_out` of the channel's second neighbour: channel 0 of the same group for channel 2, and channel n+1 of the previous group (ring) for channels 0 and 1.
- R8: With `ext_mode` = 1, gate code 6 gives the inverted gate pin and code 7 gives the non-inverted second-neighbour output. Codes 8, 9 and 10 pass `pat_present`, `pat_occurred` and `pat_gone`, and codes 11, 12 and 13 give their complements. All other gate codes drive the gate low: 4, 5 and 14 to 31 in extended mode, and 4 to 31 otherwise.
- R9: `clk_pin_oe[i]` is 1 exactly when channel i's clock code is not 0. `gate_pin_oe[i]` is 1 exactly when its gate code is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Enables the extended clock and gate codes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: {channel, clock/gate select} |
| reg_wdata | input | 5 | Write data (source code) |
| reg_rdata | output | 5 | Read data of the addressed register |
| clk_pin_in | input | NCH | Per-channel clock connector pin level |
| gate_pin_in | input | NCH | Per-channel gate connector pin level |
| grp_ext_clk | input | NUM_GRP | Shared external clock, one per group |
| ctr_out | input | NCH | Counter channel output levels |
| pat_present | input | 1 | Pattern currently present |
| pat_occurred | input | 1 | Latched pattern-occurred status |
| pat_gone | input | 1 | Latched pattern-gone status |
| clk_tick | output | NCH | One-cycle count enable per channel |
| gate_lvl | output | NCH | Selected gate level per channel |
| clk_pin_oe | output | NCH | Clock pin output enable |
| gate_pin_oe | output | NCH | Gate pin output enable |

## Verification
The bench builds the block with two groups of three channels, FIRST_DIV = 2 and DEC_DIV = 4. The internal tick periods are then 2, 8, 32, 128 and 512 cycles. A 1024-cycle window is a whole multiple of every period, so each rate can be checked by an exact tick count whatever its phase. Two groups are the smallest setting in which the neighbour ring both crosses a group boundary and wraps from group 0 back to the last group. Every clock link and every second-neighbour gate link is therefore driven individually.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
   // Source codes are 5 bits wide; their values are behaviour, not layout.
   localparam int CODE_W = 5;

   // clock-select codes
   localparam logic [CODE_W-1:0] CK_PIN   = 5'd0;
   localparam logic [CODE_W-1:0] CK_R0    = 5'd1;
   localparam logic [CODE_W-1:0] CK_R1    = 5'd2;
   localparam logic [CODE_W-1:0] CK_R2    = 5'd3;
   localparam logic [CODE_W-1:0] CK_R3    = 5'd4;
   localparam logic [CODE_W-1:0] CK_R4    = 5'd5;
   localparam logic [CODE_W-1:0] CK_PREV  = 5'd6;
   localparam logic [CODE_W-1:0] CK_EXT   = 5'd7;
   localparam logic [CODE_W-1:0] CK_HIGH  = 5'd8;
   localparam logic [CODE_W-1:0] CK_LOW   = 5'd9;
   localparam logic [CODE_W-1:0] CK_PAT   = 5'd10;
   localparam logic [CODE_W-1:0] CK_SYS   = 5'd11;

   // gate-select codes
   localparam logic [CODE_W-1:0] GT_ON    = 5'd0;
   localparam logic [CODE_W-1:0] GT_OFF   = 5'd1;
   localparam logic [CODE_W-1:0] GT_PIN   = 5'd2;
   localparam logic [CODE_W-1:0] GT_NB2N  = 5'd3;
   localparam logic [CODE_W-1:0] GT_PINN  = 5'd6;
   localparam logic [CODE_W-1:0] GT_NB2   = 5'd7;
   localparam logic [CODE_W-1:0] GT_PP    = 5'd8;
   localparam logic [CODE_W-1:0] GT_PO    = 5'd9;
   localparam logic [CODE_W-1:0] GT_PG    = 5'd10;
   localparam logic [CODE_W-1:0] GT_PPN   = 5'd11;
   localparam logic [CODE_W-1:0] GT_PON   = 5'd12;
   localparam logic [CODE_W-1:0] GT_PGN   = 5'd13;

   // number of divided internal rates
   localparam int NUM_RATES = 5;
endpackage

// File: rtl/ctr_route_tickgen.sv
module ctr_route_tickgen
   import ctr_route_pkg::*;
#(
   parameter int FIRST_DIV = 2,
   parameter int DEC_DIV   = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [NUM_RATES-1:0] rate_tick
);
   localparam int MAX_DIV = (FIRST_DIV > DEC_DIV) ? FIRST_DIV : DEC_DIV;
   localparam int CW      = $clog2(MAX_DIV) + 1;

   if (FIRST_DIV < 2) begin : g_bad_first
      $error("ctr_route_tickgen: FIRST_DIV must be at least 2");
   end
   if (DEC_DIV < 2) begin : g_bad_dec
      $error("ctr_route_tickgen: DEC_DIV must be at least 2");
   end

   // Cascade: stage 0 divides the system clock, later stages divide the
   // previous stage's pulses.
   for (genvar k = 0; k < NUM_RATES; k++) begin : g_stage
      localparam int DIV_K = (k == 0) ? FIRST_DIV : DEC_DIV;
      logic          stage_in;
      logic [CW-1:0] cnt;

      if (k == 0) begin : g_head
         assign stage_in = 1'b1;
      end else begin : g_tail
         assign stage_in = rate_tick[k-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (stage_in)
            cnt <= (cnt == CW'(DIV_K - 1)) ? '0 : cnt + 1'b1;
      end

      assign rate_tick[k] = stage_in && (cnt == CW'(DIV_K - 1));
   end
endmodule

// File: rtl/ctr_route_regs.sv
module ctr_route_regs
   import ctr_route_pkg::*;
#(
   parameter int NCH    = 6,
   parameter int ADDR_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [CODE_W-1:0]           wdata,
   output logic [CODE_W-1:0]           rdata,
   output logic [NCH-1:0][CODE_W-1:0]  clk_code,
   output logic [NCH-1:0][CODE_W-1:0]  gate_code
);
   localparam int IDX_W = ADDR_W - 1;

   if ((1 << IDX_W) < NCH) begin : g_bad_addr
      $error("ctr_route_regs: ADDR_W too narrow for NCH");
   end

   logic [IDX_W-1:0] idx;
   logic             is_gate;
   assign idx     = addr[ADDR_W-1:1];
   assign is_gate = addr[0];

   for (genvar i = 0; i < NCH; i++) begin : g_reg
      logic hit;
      assign hit = wr && (idx == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            clk_code[i]  <= '0;
            gate_code[i] <= '0;
         end else if (hit) begin
            if (is_gate) gate_code[i] <= wdata;
            else         clk_code[i]  <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (idx == IDX_W'(i))
            rdata = is_gate ? gate_code[i] : clk_code[i];
      end
   end
endmodule

// File: rtl/ctr_route_chan.sv
module ctr_route_chan
   import ctr_route_pkg::*;
(
   input  logic                 ext_mode,
   input  logic [CODE_W-1:0]    clk_code,
   input  logic [CODE_W-1:0]    gate_code,
   input  logic                 pin_rise,
   input  logic                 ext_rise,
   input  logic                 prev_rise,
   input  logic                 pat_rise,
   input  logic [NUM_RATES-1:0] rate_tick,
   input  logic                 gate_pin,
   input  logic                 nb2_out,
   input  logic                 pat_present,
   input  logic                 pat_occurred,
   input  logic                 pat_gone,
   output logic                 clk_tick,
   output logic                 gate_lvl,
   output logic                 clk_oe,
   output logic                 gate_oe
);
   always_comb begin
      unique case (clk_code)
         CK_PIN:  clk_tick = pin_rise;
         CK_R0:   clk_tick = rate_tick[0];
         CK_R1:   clk_tick = rate_tick[1];
         CK_R2:   clk_tick = rate_tick[2];
         CK_R3:   clk_tick = rate_tick[3];
         CK_R4:   clk_tick = rate_tick[4];
         CK_PREV: clk_tick = prev_rise;
         CK_EXT:  clk_tick = ext_rise;
         CK_PAT:  clk_tick = ext_mode && pat_rise;
         CK_SYS:  clk_tick = ext_mode;
         // fixed levels have no edge; unlisted codes are held low
         default: clk_tick = 1'b0;
      endcase
   end

   always_comb begin
      unique case (gate_code)
         GT_ON:   gate_lvl = 1'b1;
         GT_OFF:  gate_lvl = 1'b0;
         GT_PIN:  gate_lvl = gate_pin;
         GT_NB2N: gate_lvl = !nb2_out;
         GT_PINN: gate_lvl = ext_mode && !gate_pin;
         GT_NB2:  gate_lvl = ext_mode && nb2_out;
         GT_PP:   gate_lvl = ext_mode && pat_present;
         GT_PO:   gate_lvl = ext_mode && pat_occurred;
         GT_PG:   gate_lvl = ext_mode && pat_gone;
         GT_PPN:  gate_lvl = ext_mode && !pat_present;
         GT_PON:  gate_lvl = ext_mode && !pat_occurred;
         GT_PGN:  gate_lvl = ext_mode && !pat_gone;
         default: gate_lvl = 1'b0;
      endcase
   end

   assign clk_oe  = (clk_code != CK_PIN);
   assign gate_oe = (gate_code != GT_PIN);
endmodule

// File: rtl/ctr_route_matrix.sv
module ctr_route_matrix
   import ctr_route_pkg::*;
#(
   parameter int NUM_GRP    = 2,
   parameter int CH_PER_GRP = 3,
   parameter int FIRST_DIV  = 2,
   parameter int DEC_DIV    = 10,
   localparam int NCH       = NUM_GRP * CH_PER_GRP,
   localparam int ADDR_W    = $clog2(NCH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_mode,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [CODE_W-1:0]  reg_wdata,
   output logic [CODE_W-1:0]  reg_rdata,
   input  logic [NCH-1:0]     clk_pin_in,
   input  logic [NCH-1:0]     gate_pin_in,
   input  logic [NUM_GRP-1:0] grp_ext_clk,
   input  logic [NCH-1:0]     ctr_out,
   input  logic               pat_present,
   input  logic               pat_occurred,
   input  logic               pat_gone,
   output logic [NCH-1:0]     clk_tick,
   output logic [NCH-1:0]     gate_lvl,
   output logic [NCH-1:0]     clk_pin_oe,
   output logic [NCH-1:0]     gate_pin_oe
);
   if (CH_PER_GRP != 3) begin : g_bad_grp
      $error("ctr_route_matrix: neighbour links need three channels per group");
   end
   if (NUM_GRP < 1) begin : g_bad_num
      $error("ctr_route_matrix: NUM_GRP must be at least 1");
   end

   logic [NCH-1:0][CODE_W-1:0] clk_code;
   logic [NCH-1:0][CODE_W-1:0] gate_code;
   logic [NUM_RATES-1:0]       rate_tick;

   ctr_route_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .clk_code  (clk_code),
      .gate_code (gate_code)
   );

   ctr_route_tickgen #(.FIRST_DIV(FIRST_DIV), .DEC_DIV(DEC_DIV)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_tick (rate_tick)
   );

   // rising-edge detection of every level source that can clock a channel
   logic [NCH-1:0]     pin_q, co_q;
   logic [NUM_GRP-1:0] ext_q;
   logic               pat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= '0;
         co_q  <= '0;
         ext_q <= '0;
         pat_q <= 1'b0;
      end else begin
         pin_q <= clk_pin_in;
         co_q  <= ctr_out;
         ext_q <= grp_ext_clk;
         pat_q <= pat_present;
      end
   end

   logic [NCH-1:0]     pin_rise, co_rise;
   logic [NUM_GRP-1:0] ext_rise;
   assign pin_rise = clk_pin_in & ~pin_q;
   assign co_rise  = ctr_out & ~co_q;
   assign ext_rise = grp_ext_clk & ~ext_q;

   // With three channels per group the ring collapses to flat indices:
   // clock neighbour is i-1, gate second neighbour is i-2 (modulo NCH).
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int PREV = (i + NCH - 1) % NCH;
      localparam int NB2  = (i + NCH - 2) % NCH;
      localparam int GRP  = i / CH_PER_GRP;

      ctr_route_chan u_chan (
         .ext_mode     (ext_mode),
         .clk_code     (clk_code[i]),
         .gate_code    (gate_code[i]),
         .pin_rise     (pin_rise[i]),
         .ext_rise     (ext_rise[GRP]),
         .prev_rise    (co_rise[PREV]),
         .pat_rise     (pat_present && !pat_q),
         .rate_tick    (rate_tick),
         .gate_pin     (gate_pin_in[i]),
         .nb2_out      (ctr_out[NB2]),
         .pat_present  (pat_present),
         .pat_occurred (pat_occurred),
         .pat_gone     (pat_gone),
         .clk_tick     (clk_tick[i]),
         .gate_lvl     (gate_lvl[i]),
         .clk_oe       (clk_pin_oe[i]),
         .gate_oe      (gate_pin_oe[i])
      );
   end
endmodule

// File: rtl/ctr_route_matrix_chk.sv
module ctr_route_matrix_chk
   import ctr_route_pkg::*;
#(
   parameter int NUM_GRP    = 2,
   parameter int CH_PER_GRP = 3,
   localparam int NCH       = NUM_GRP * CH_PER_GRP,
   localparam int ADDR_W    = $clog2(NCH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CODE_W-1:0] reg_wdata,
   input logic [NCH-1:0]    clk_pin_in,
   input logic [NCH-1:0]    clk_tick,
   input logic [NCH-1:0]    gate_lvl,
   input logic [NCH-1:0]    clk_pin_oe,
   input logic [NCH-1:0]    gate_pin_oe
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (clk_pin_oe == '0 && gate_pin_oe == '1));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R9
      clk_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == ADDR_W'(2*i))
         |=> (clk_pin_oe[i] == ($past(reg_wdata) != 5'd0)));
      // R9
      gate_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == ADDR_W'(2*i+1))
         |=> (gate_pin_oe[i] == ($past(reg_wdata) != 5'd2)));
      // R7
      gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == ADDR_W'(2*i+1) && reg_wdata == 5'd1)
         |=> !gate_lvl[i]);
      // R6
      low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == ADDR_W'(2*i) && reg_wdata == 5'd9)
         |=> !clk_tick[i]);
      // R3
      pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && !clk_pin_oe[i])
         |-> (clk_tick[i] == (clk_pin_in[i] && !$past(clk_pin_in[i]))));
   end
endmodule

bind ctr_route_matrix ctr_route_matrix_chk #(
   .NUM_GRP    (NUM_GRP),
   .CH_PER_GRP (CH_PER_GRP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .clk_pin_in  (clk_pin_in),
   .clk_tick    (clk_tick),
   .gate_lvl    (gate_lvl),
   .clk_pin_oe  (clk_pin_oe),
   .gate_pin_oe (gate_pin_oe)
);

// File: tb/ctr_route_matrix_tb.sv
`timescale 1ns/1ps
module ctr_route_matrix_tb;
   localparam int NG  = 2;
   localparam int NCH = 6;
   localparam int AW  = 4;
   localparam int WIN = 1024;

   localparam int K_RD   = 0;
   localparam int K_TICK = 1;
   localparam int K_GATE = 2;
   localparam int K_COE  = 3;
   localparam int K_GOE  = 4;
   localparam int K_CNT  = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           ext_mode = 1'b1;
   logic           reg_wr = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic [4:0]     reg_wdata = '0;
   logic [4:0]     reg_rdata;
   logic [NCH-1:0] clk_pin_in = '0, gate_pin_in = '0, ctr_out = '0;
   logic [NG-1:0]  grp_ext_clk = '0;
   logic           pat_present = 1'b0, pat_occurred = 1'b0, pat_gone = 1'b0;
   logic [NCH-1:0] clk_tick, gate_lvl, clk_pin_oe, gate_pin_oe;

   ctr_route_matrix #(.NUM_GRP(NG), .CH_PER_GRP(3), .FIRST_DIV(2), .DEC_DIV(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .clk_pin_in(clk_pin_in), .gate_pin_in(gate_pin_in), .grp_ext_clk(grp_ext_clk),
      .ctr_out(ctr_out), .pat_present(pat_present), .pat_occurred(pat_occurred),
      .pat_gone(pat_gone), .clk_tick(clk_tick), .gate_lvl(gate_lvl),
      .clk_pin_oe(clk_pin_oe), .gate_pin_oe(gate_pin_oe)
   );

   typedef struct {
      int          kind;
      int          idx;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   int    tcnt[NCH];
   bit    cnt_clr = 1'b0;
   bit    done = 1'b0;
   logic [4:0] ck_code[NCH], gt_code[NCH];

   function automatic logic [31:0] observe(item_t it);
      case (it.kind)
         K_RD:    return 32'(reg_rdata);
         K_TICK:  return 32'(clk_tick);
         K_GATE:  return 32'(gate_lvl);
         K_COE:   return 32'(clk_pin_oe);
         K_GOE:   return 32'(gate_pin_oe);
         default: return 32'(tcnt[it.idx]);
      endcase
   endfunction

   // monitor: compare pending expectations, then accumulate tick counts
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t       it;
         logic [31:0] got;
         it  = q.pop_front();
         got = observe(it);
         n_chk++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                     it.req, it.kind, it.idx, got, it.exp);
         end
      end
      for (int i = 0; i < NCH; i++)
         tcnt[i] = cnt_clr ? 0 : tcnt[i] + int'(clk_tick[i]);
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push(int kind, int idx, logic [31:0] exp, string req);
      item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic wr(int ch, bit gsel, logic [4:0] v);
      reg_wr = 1'b1; reg_addr = AW'(ch*2 + int'(gsel)); reg_wdata = v;
      cyc();
      reg_wr = 1'b0;
      if (ch < NCH) begin
         if (gsel) gt_code[ch] = v; else ck_code[ch] = v;
      end
   endtask

   task automatic rd_chk(int ch, bit gsel, logic [4:0] exp, string req);
      reg_addr = AW'(ch*2 + int'(gsel));
      push(K_RD, ch, 32'(exp), req);
      cyc();
   endtask

   task automatic oe_chk(string req);
      logic [NCH-1:0] ce, ge;
      for (int i = 0; i < NCH; i++) begin
         ce[i] = (ck_code[i] != 5'd0);
         ge[i] = (gt_code[i] != 5'd2);
      end
      push(K_COE, 0, 32'(ce), req);
      push(K_GOE, 0, 32'(ge), req);
      cyc();
   endtask

   // raise a set of sources, expect one tick vector, then nothing while held and on release
   task automatic tick_step(logic [NCH-1:0] cp, logic [NG-1:0] ex, logic [NCH-1:0] co,
                            bit pp, logic [NCH-1:0] exp, string req);
      clk_pin_in = cp; grp_ext_clk = ex; ctr_out = co; pat_present = pp;
      push(K_TICK, 0, 32'(exp), req);
      cyc();
      push(K_TICK, 0, 32'(0), req);
      cyc();
      clk_pin_in = '0; grp_ext_clk = '0; ctr_out = '0; pat_present = 1'b0;
      push(K_TICK, 0, 32'(0), req);
      cyc();
   endtask

   function automatic logic gate_model(logic [4:0] code, int i, bit ext,
                                       logic [NCH-1:0] gp, logic [NCH-1:0] co,
                                       bit pp, bit po, bit pg);
      int g  = i / 3;
      int c  = i % 3;
      int n2 = (c == 2) ? g*3 : (((g + NG - 1) % NG) * 3 + c + 1);
      case (code)
         5'd0:  return 1'b1;
         5'd1:  return 1'b0;
         5'd2:  return gp[i];
         5'd3:  return !co[n2];
         5'd6:  return ext && !gp[i];
         5'd7:  return ext && co[n2];
         5'd8:  return ext && pp;
         5'd9:  return ext && po;
         5'd10: return ext && pg;
         5'd11: return ext && !pp;
         5'd12: return ext && !po;
         5'd13: return ext && !pg;
         default: return 1'b0;
      endcase
   endfunction

   task automatic gate_cfg(logic [4:0] c0, logic [4:0] c1, logic [4:0] c2,
                           logic [4:0] c3, logic [4:0] c4, logic [4:0] c5,
                           bit ext, string req);
      logic [4:0] cs[NCH];
      logic [NCH-1:0] gp_pat[3];
      logic [NCH-1:0] co_pat[3];
      logic [2:0]     pt_pat[3];
      cs = '{c0, c1, c2, c3, c4, c5};
      gp_pat = '{6'b101010, 6'b010101, 6'b000000};
      co_pat = '{6'b110001, 6'b001110, 6'b111111};
      pt_pat = '{3'b101, 3'b010, 3'b111};
      ext_mode = ext;
      for (int i = 0; i < NCH; i++) wr(i, 1'b1, cs[i]);
      oe_chk({req, " R9"});
      for (int p = 0; p < 3; p++) begin
         logic [NCH-1:0] e;
         gate_pin_in = gp_pat[p]; ctr_out = co_pat[p];
         {pat_present, pat_occurred, pat_gone} = pt_pat[p];
         for (int i = 0; i < NCH; i++)
            e[i] = gate_model(cs[i], i, ext, gp_pat[p], co_pat[p],
                              pt_pat[p][2], pt_pat[p][1], pt_pat[p][0]);
         push(K_GATE, p, 32'(e), req);
         cyc();
      end
      gate_pin_in = '0; ctr_out = '0;
      {pat_present, pat_occurred, pat_gone} = 3'b000;
      cyc();
   endtask

   task automatic rate_window(int exp0, int exp1, int exp2, int exp3, int exp4, int exp5,
                              string req);
      int ex[NCH];
      ex = '{exp0, exp1, exp2, exp3, exp4, exp5};
      cnt_clr = 1'b1;
      cyc();
      cnt_clr = 1'b0;
      repeat (WIN) cyc();
      for (int i = 0; i < NCH; i++) push(K_CNT, i, 32'(ex[i]), req);
      cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin ck_code[i] = 5'd0; gt_code[i] = 5'd0; end
      repeat (4) cyc();
      rst_n = 1'b1;

      // R1: reset contents
      for (int i = 0; i < NCH; i++) begin
         rd_chk(i, 1'b0, 5'd0, "R1 clk code after reset");
         rd_chk(i, 1'b1, 5'd0, "R1 gate code after reset");
      end
      push(K_COE, 0, 32'(6'b000000), "R1 clk oe after reset");
      push(K_GOE, 0, 32'(6'b111111), "R1 gate oe after reset");
      cyc();

      // R2: write and read back every register
      for (int i = 0; i < NCH; i++) begin
         wr(i, 1'b0, 5'(i + 20));
         wr(i, 1'b1, 5'(i + 3));
      end
      for (int i = 0; i < NCH; i++) begin
         rd_chk(i, 1'b0, 5'(i + 20), "R2 clk readback");
         rd_chk(i, 1'b1, 5'(i + 3), "R2 gate readback");
      end
      // R2: unused channel slots read 0 and writes to them change nothing
      wr(7, 1'b0, 5'd31);
      wr(6, 1'b1, 5'd17);
      rd_chk(7, 1'b0, 5'd0, "R2 unused slot read");
      rd_chk(6, 1'b1, 5'd0, "R2 unused slot read");
      for (int i = 0; i < NCH; i++)
         rd_chk(i, 1'b0, 5'(i + 20), "R2 no alias of unused slot");
      rd_chk(3, 1'b1, 5'd6, "R2 no alias of unused slot");

      // R3 / R5 / R6: edge sources
      ext_mode = 1'b1;
      wr(0, 1'b0, 5'd0);  wr(1, 1'b0, 5'd7);  wr(2, 1'b0, 5'd6);
      wr(3, 1'b0, 5'd6);  wr(4, 1'b0, 5'd10); wr(5, 1'b0, 5'd7);
      repeat (2) cyc();
      tick_step(6'b000011, 2'b00, 6'b000000, 1'b0, 6'b000001, "R3 own pin edge");
      tick_step(6'b000000, 2'b01, 6'b000000, 1'b0, 6'b000010, "R3 group0 ext clock");
      tick_step(6'b000000, 2'b10, 6'b000000, 1'b0, 6'b100000, "R3 group1 ext clock");
      tick_step(6'b000000, 2'b00, 6'b000010, 1'b0, 6'b000100, "R5 prev in group");
      tick_step(6'b000000, 2'b00, 6'b000100, 1'b0, 6'b001000, "R5 prev across groups");
      tick_step(6'b000000, 2'b00, 6'b000000, 1'b1, 6'b010000, "R6 pattern edge");
      wr(0, 1'b0, 5'd6);
      cyc();
      tick_step(6'b000001, 2'b00, 6'b100000, 1'b0, 6'b000001, "R5 ring wrap to ch0");
      ext_mode = 1'b0;
      cyc();
      tick_step(6'b000000, 2'b00, 6'b000000, 1'b1, 6'b000000, "R6 pattern code off");

      // R4: internal rates over a whole-period window
      ext_mode = 1'b1;
      wr(0, 1'b0, 5'd1); wr(1, 1'b0, 5'd2); wr(2, 1'b0, 5'd3);
      wr(3, 1'b0, 5'd4); wr(4, 1'b0, 5'd5); wr(5, 1'b0, 5'd11);
      rate_window(512, 128, 32, 8, 2, 1024, "R4 internal rates");

      // R6: silent codes
      wr(0, 1'b0, 5'd8); wr(1, 1'b0, 5'd9); wr(2, 1'b0, 5'd12);
      wr(3, 1'b0, 5'd31); wr(4, 1'b0, 5'd10); wr(5, 1'b0, 5'd11);
      ext_mode = 1'b0;
      pat_present = 1'b1;
      rate_window(0, 0, 0, 0, 0, 0, "R6 silent clock codes");
      pat_present = 1'b0;
      oe_chk("R9 clk oe codes");

      // R7 / R8: gate selection
      gate_cfg(5'd0, 5'd1, 5'd2, 5'd3, 5'd6, 5'd7, 1'b1, "R7 base gate codes");
      gate_cfg(5'd3, 5'd3, 5'd3, 5'd7, 5'd7, 5'd7, 1'b1, "R7 second neighbour");
      gate_cfg(5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 1'b1, "R8 pattern gates");
      gate_cfg(5'd4, 5'd5, 5'd14, 5'd31, 5'd3, 5'd2, 1'b1, "R8 reserved gates");
      gate_cfg(5'd6, 5'd7, 5'd8, 5'd11, 5'd4, 5'd3, 1'b0, "R8 non-extended gates");

      repeat (2) cyc();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule